// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits beside a cluster of four processor cores and decides, for every local interrupt source, which core sees it and whether it arrives as a normal interrupt (IRQ) or a fast interrupt (FIQ). Each core owns four timer inputs and four mailbox inputs. Two more sources are shared. A GPU interrupt is steered to one selectable core for IRQ and to one selectable core for FIQ. A performance-monitor interrupt is gated by a per-core enable that software sets and clears through two separate write-one registers.

All interrupt sources arrive as level signals, and the block holds no interrupt state of its own. The only storage is the enable and steering configuration. From the configuration and the live levels, the block composes a 10-bit IRQ-pending word and a 10-bit FIQ-pending word for each core. It reduces each word to that core's interrupt line and makes both words readable on a simple register port. The register port has one address, one write strobe, write data and combinational read data. It has no handshake.

The block has no sequencing, so it contains no state machine. Its behaviour is the register file plus pure combinational routing, and the brief therefore names no states or transitions.

Top module: `lir_router`

## Requirements
- R1: After reset every timer and mailbox control register, the PMU enable and the GPU steering register read 0. With the GPU input low, no core's IRQ or FIQ line is active, whatever the other source levels are. With steering 0, a high GPU input reaches core 0 on both IRQ and FIQ.
- R2: Core c's timer control register sits at 0x40+4c and its mailbox control register at 0x50+4c. Bits 3:0 are the IRQ enables of sources 0..3 and bits 7:4 their FIQ enables. A write stores wdata[7:0], and a read returns those 8 bits with the upper bits zero.
- R3: A timer source k of core c (input bit 4c+k) that is high raises pending bit k. It goes in the FIQ word when its FIQ enable is set; otherwise it goes in the IRQ word when its IRQ enable is set. A source never appears in both words.
- R4: A mailbox source k of core c (input bit 4c+k) follows the same enable rule using the mailbox control register, and lands on pending bit 4+k.
- R5: The GPU steering register at 0x0C holds the IRQ target core in bits 1:0 and the FIQ target core in bits 3:2. A high GPU input sets bit 8 of the IRQ word of the IRQ target and bit 8 of the FIQ word of the FIQ target. No other core sees it.
- R6: Writing 0x10 sets the PMU enable bits where wdata has ones. Writing 0x14 clears them. Zero bits leave the enable unchanged. Both addresses read the 4-bit enable.
- R7: A high PMU input sets bit 9 of the IRQ word of every core whose PMU enable is set. It never sets an FIQ bit.
- R8: The IRQ-pending word of core c reads at 0x60+4c and the FIQ-pending word at 0x70+4c, in bits 9:0. Writes to these addresses change nothing.
- R9: A core's IRQ line is high exactly when its IRQ word is non-zero, and its FIQ line is high exactly when its FIQ word is non-zero.
- R10: Unmapped addresses read 0, and writes to them change no configuration.
- R11: A configuration write takes effect on the clock edge that samples it. A change in any source level reaches the pending words and lines in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| timer_lvl | input | 16 | Timer levels, bit 4c+k is core c timer k |
| mbox_lvl | input | 16 | Mailbox levels, bit 4c+k is core c mailbox k |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 1 | Shared performance-monitor interrupt level |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
Source levels pass through combinational logic only. The bench therefore drives levels on the falling edge and samples the lines and pending reads one time unit later, in the same cycle. A configuration write is held across exactly one rising edge. Its effect is checked after the next falling edge, and in the R11 test also just before that edge, to confirm the old setting still holds. Reads are combinational on bus_addr and are sampled one time unit after the address changes, away from any clock edge.

// File: rtl/lir_pkg.sv
package lir_pkg;
    localparam int ADDR_W   = 8;
    localparam int NSRC_DEF = 4;

    localparam logic [ADDR_W-1:0] A_GPU_STEER = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PMU_SET   = 8'h10;
    localparam logic [ADDR_W-1:0] A_PMU_CLR   = 8'h14;
    localparam logic [ADDR_W-1:0] A_TIM_BASE  = 8'h40;
    localparam logic [ADDR_W-1:0] A_MBX_BASE  = 8'h50;
    localparam logic [ADDR_W-1:0] A_IRQP_BASE = 8'h60;
    localparam logic [ADDR_W-1:0] A_FIQP_BASE = 8'h70;

    localparam int STEER_W = 2;

    function automatic logic [ADDR_W-1:0] core_addr(logic [ADDR_W-1:0] base, int core);
        return base + ADDR_W'(4 * core);
    endfunction
endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NSRC  = NSRC_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*NSRC-1:0]       wdata,
    output logic [NCORE*2*NSRC-1:0] tim_ctl,
    output logic [NCORE*2*NSRC-1:0] mbx_ctl,
    output logic [2*STEER_W-1:0]    gpu_steer,
    output logic [NCORE-1:0]        pmu_en
);
    localparam int CW = 2 * NSRC;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam logic [ADDR_W-1:0] A_TIM = core_addr(A_TIM_BASE, c);
        localparam logic [ADDR_W-1:0] A_MBX = core_addr(A_MBX_BASE, c);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tim_ctl[c*CW +: CW] <= '0;
                mbx_ctl[c*CW +: CW] <= '0;
            end else if (we) begin
                if (addr == A_TIM) tim_ctl[c*CW +: CW] <= wdata;
                if (addr == A_MBX) mbx_ctl[c*CW +: CW] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpu_steer <= '0;
        end else if (we && addr == A_GPU_STEER) begin
            gpu_steer <= wdata[2*STEER_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmu_en <= '0;
        end else if (we && addr == A_PMU_SET) begin
            pmu_en <= pmu_en | wdata[NCORE-1:0];
        end else if (we && addr == A_PMU_CLR) begin
            pmu_en <= pmu_en & ~wdata[NCORE-1:0];
        end
    end
endmodule

// File: rtl/lir_core_route.sv
module lir_core_route #(
    parameter int NSRC = 4
) (
    input  logic [2*NSRC-1:0] tim_ctl,
    input  logic [2*NSRC-1:0] mbx_ctl,
    input  logic [NSRC-1:0]   tim_lvl,
    input  logic [NSRC-1:0]   mbx_lvl,
    input  logic              gpu_to_irq,
    input  logic              gpu_to_fiq,
    input  logic              pmu_hit,
    output logic [2*NSRC+1:0] irq_pend,
    output logic [2*NSRC+1:0] fiq_pend,
    output logic              irq,
    output logic              fiq
);
    logic [NSRC-1:0] tim_fiq, tim_irq, mbx_fiq, mbx_irq;

    always_comb begin
        tim_fiq = tim_lvl & tim_ctl[2*NSRC-1:NSRC];
        tim_irq = tim_lvl & tim_ctl[NSRC-1:0] & ~tim_ctl[2*NSRC-1:NSRC];
        mbx_fiq = mbx_lvl & mbx_ctl[2*NSRC-1:NSRC];
        mbx_irq = mbx_lvl & mbx_ctl[NSRC-1:0] & ~mbx_ctl[2*NSRC-1:NSRC];
        irq_pend = {pmu_hit, gpu_to_irq, mbx_irq, tim_irq};
        fiq_pend = {1'b0, gpu_to_fiq, mbx_fiq, tim_fiq};
        irq = |irq_pend;
        fiq = |fiq_pend;
    end
endmodule

// File: rtl/lir_router.sv
module lir_router
    import lir_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int NSRC   = NSRC_DEF,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NCORE*NSRC-1:0] timer_lvl,
    input  logic [NCORE*NSRC-1:0] mbox_lvl,
    input  logic                  gpu_lvl,
    input  logic                  pmu_lvl,
    output logic [NCORE-1:0]      core_irq,
    output logic [NCORE-1:0]      core_fiq
);
    localparam int CW = 2 * NSRC;
    localparam int PW = 2 * NSRC + 2;

    logic [NCORE*CW-1:0]      tim_ctl;
    logic [NCORE*CW-1:0]      mbx_ctl;
    logic [2*STEER_W-1:0]     gpu_steer;
    logic [NCORE-1:0]         pmu_en;
    logic [NCORE*PW-1:0]      irq_pend_all;
    logic [NCORE*PW-1:0]      fiq_pend_all;
    logic [DATA_W-1:CW]       unused_wdata;

    assign unused_wdata = bus_wdata[DATA_W-1:CW];

    lir_regs #(.NCORE(NCORE), .NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata[CW-1:0]),
        .tim_ctl   (tim_ctl),
        .mbx_ctl   (mbx_ctl),
        .gpu_steer (gpu_steer),
        .pmu_en    (pmu_en)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_route
        logic gpu_i, gpu_f;
        assign gpu_i = gpu_lvl && (gpu_steer[STEER_W-1:0] == STEER_W'(c));
        assign gpu_f = gpu_lvl && (gpu_steer[2*STEER_W-1:STEER_W] == STEER_W'(c));

        lir_core_route #(.NSRC(NSRC)) u_core (
            .tim_ctl    (tim_ctl[c*CW +: CW]),
            .mbx_ctl    (mbx_ctl[c*CW +: CW]),
            .tim_lvl    (timer_lvl[c*NSRC +: NSRC]),
            .mbx_lvl    (mbox_lvl[c*NSRC +: NSRC]),
            .gpu_to_irq (gpu_i),
            .gpu_to_fiq (gpu_f),
            .pmu_hit    (pmu_lvl & pmu_en[c]),
            .irq_pend   (irq_pend_all[c*PW +: PW]),
            .fiq_pend   (fiq_pend_all[c*PW +: PW]),
            .irq        (core_irq[c]),
            .fiq        (core_fiq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_GPU_STEER) begin
            bus_rdata[2*STEER_W-1:0] = gpu_steer;
        end
        if (bus_addr == A_PMU_SET || bus_addr == A_PMU_CLR) begin
            bus_rdata[NCORE-1:0] = pmu_en;
        end
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == core_addr(A_TIM_BASE, c))  bus_rdata[CW-1:0] = tim_ctl[c*CW +: CW];
            if (bus_addr == core_addr(A_MBX_BASE, c))  bus_rdata[CW-1:0] = mbx_ctl[c*CW +: CW];
            if (bus_addr == core_addr(A_IRQP_BASE, c)) bus_rdata[PW-1:0] = irq_pend_all[c*PW +: PW];
            if (bus_addr == core_addr(A_FIQP_BASE, c)) bus_rdata[PW-1:0] = fiq_pend_all[c*PW +: PW];
        end
    end
endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk
    import lir_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NSRC  = 4,
    parameter int CFG_W = 4 * NSRC * NCORE + 2 * STEER_W + NCORE
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [NCORE-1:0]            wbits,
    input logic                        pmu_lvl,
    input logic [NCORE-1:0]            pmu_en,
    input logic [CFG_W-1:0]            cfg,
    input logic [NCORE*(2*NSRC+2)-1:0] irq_pend_all,
    input logic [NCORE*(2*NSRC+2)-1:0] fiq_pend_all
);
    localparam int PW = 2 * NSRC + 2;

    logic [NCORE-1:0] gpu_irq_bits, pmu_irq_bits;
    logic             pmu_wr, pend_wr;

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            gpu_irq_bits[c] = irq_pend_all[c*PW + 2*NSRC];
            pmu_irq_bits[c] = irq_pend_all[c*PW + 2*NSRC + 1];
        end
        pmu_wr  = bus_we && (bus_addr == A_PMU_SET || bus_addr == A_PMU_CLR);
        pend_wr = bus_we && (bus_addr[7:5] == 3'b011);
    end

    AST_PMU_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PMU_SET) |=> ((pmu_en & $past(wbits)) == $past(wbits))); // R6
    AST_PMU_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PMU_CLR) |=> ((pmu_en & $past(wbits)) == '0)); // R6
    AST_PMU_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pmu_wr |=> $stable(pmu_en)); // R6
    AST_PEND_RO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> $stable(cfg)); // R8
    AST_GPU_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpu_irq_bits)); // R5
    AST_PMU_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pmu_lvl |-> (pmu_irq_bits == '0)); // R7

    for (genvar c = 0; c < NCORE; c++) begin : g_ovr
        AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_pend_all[c*PW +: 2*NSRC] & fiq_pend_all[c*PW +: 2*NSRC]) == '0)); // R3
    end
endmodule

bind lir_router lir_router_chk #(.NCORE(NCORE), .NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .wbits        (bus_wdata[NCORE-1:0]),
    .pmu_lvl      (pmu_lvl),
    .pmu_en       (pmu_en),
    .cfg          ({tim_ctl, mbx_ctl, gpu_steer, pmu_en}),
    .irq_pend_all (irq_pend_all),
    .fiq_pend_all (fiq_pend_all)
);

// File: tb/sim_lir_router.sv
module sim_lir_router;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [15:0] timer_lvl = 0;
    logic [15:0] mbox_lvl = 0;
    logic        gpu_lvl = 0;
    logic        pmu_lvl = 0;
    logic [3:0]  core_irq, core_fiq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lir_router u0 (.*);

    // {timer, mailbox, gpu, pmu, expected irq, expected fiq}
    localparam logic [41:0] VEC [13] = '{
        {16'h0000, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
        {16'h000F, 16'h0000, 1'b0, 1'b0, 4'b0001, 4'b0000},
        {16'h00F0, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0010},
        {16'h0100, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0100},
        {16'h0400, 16'h0000, 1'b0, 1'b0, 4'b0100, 4'b0000},
        {16'h0800, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
        {16'hF000, 16'h0000, 1'b0, 1'b0, 4'b0000, 4'b0000},
        {16'h0000, 16'h1000, 1'b0, 1'b0, 4'b1000, 4'b0000},
        {16'h0000, 16'h8000, 1'b0, 1'b0, 4'b0000, 4'b1000},
        {16'h0000, 16'h0FFF, 1'b0, 1'b0, 4'b0000, 4'b0000},
        {16'h0000, 16'h0000, 1'b1, 1'b0, 4'b0100, 4'b1000},
        {16'h0000, 16'h0000, 1'b0, 1'b1, 4'b0010, 4'b0000},
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 4'b1111, 4'b1110}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic drive(input logic [15:0] t, input logic [15:0] m, input logic g, input logic p);
        @(negedge clk);
        timer_lvl = t; mbox_lvl = m; gpu_lvl = g; pmu_lvl = p;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd_chk("R1 tim0", 8'h40, 0);
        rd_chk("R1 mbx3", 8'h5C, 0);
        rd_chk("R1 steer", 8'h0C, 0);
        rd_chk("R1 pmu", 8'h10, 0);
        drive(16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
        check("R1 irq quiet", {28'b0, core_irq}, 0);
        check("R1 fiq quiet", {28'b0, core_fiq}, 0);
        drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        check("R1 gpu core0 irq", {28'b0, core_irq}, 32'h1);
        check("R1 gpu core0 fiq", {28'b0, core_fiq}, 32'h1);
        drive(0, 0, 0, 0);

        // configuration
        wr(8'h40, 32'h0F);
        wr(8'h44, 32'hF0);
        wr(8'h48, 32'hFFFFFF35);
        wr(8'h4C, 32'h00);
        wr(8'h5C, 32'h81);
        wr(8'h0C, 32'h0E);
        wr(8'h10, 32'h2);
        rd_chk("R2 tim readback masked", 8'h48, 32'h35);
        rd_chk("R2 mbx readback", 8'h5C, 32'h81);
        rd_chk("R5 steer readback", 8'h0C, 32'hE);

        // R3 R4 R5 R7 R9: vector table
        for (int i = 0; i < 13; i++) begin
            drive(VEC[i][41:26], VEC[i][25:10], VEC[i][9], VEC[i][8]);
            check($sformatf("R3/R4/R5/R7 R9 irq vec%0d", i), {28'b0, core_irq}, {28'b0, VEC[i][7:4]});
            check($sformatf("R3/R4/R5/R7 R9 fiq vec%0d", i), {28'b0, core_fiq}, {28'b0, VEC[i][3:0]});
        end

        // R8: pending readback with all sources high
        rd_chk("R8 irqp core0", 8'h60, 32'h00F);
        rd_chk("R8 irqp core1 pmu", 8'h64, 32'h200);
        rd_chk("R8 irqp core2", 8'h68, 32'h104);
        rd_chk("R8 fiqp core2", 8'h78, 32'h003);
        rd_chk("R8 irqp core3", 8'h6C, 32'h010);
        rd_chk("R8 fiqp core3", 8'h7C, 32'h180);
        rd_chk("R8 fiqp core1", 8'h74, 32'h00F);
        wr(8'h60, 32'hFFFFFFFF);
        wr(8'h74, 32'hFFFFFFFF);
        rd_chk("R8 write ignored tim0", 8'h40, 32'h0F);
        rd_chk("R8 write ignored tim1", 8'h44, 32'hF0);
        rd_chk("R8 write ignored irqp0", 8'h60, 32'h00F);
        drive(0, 0, 0, 0);

        // R6: PMU set/clear
        wr(8'h14, 32'hF);
        rd_chk("R6 clear all", 8'h10, 0);
        wr(8'h10, 32'h5);
        rd_chk("R6 set 5", 8'h14, 32'h5);
        wr(8'h10, 32'h2);
        rd_chk("R6 set adds", 8'h10, 32'h7);
        wr(8'h14, 32'h4);
        rd_chk("R6 clr bit2", 8'h10, 32'h3);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0);
        rd_chk("R6 zero writes keep", 8'h14, 32'h3);
        drive(0, 0, 0, 1);
        check("R7 pmu cores 0,1", {28'b0, core_irq}, 32'h3);
        check("R7 pmu no fiq", {28'b0, core_fiq}, 0);
        drive(0, 0, 0, 0);

        // R10: unmapped
        rd_chk("R10 read 0x20", 8'h20, 0);
        rd_chk("R10 read 0x41", 8'h41, 0);
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h42, 32'hFFFFFFFF);
        rd_chk("R10 tim0 kept", 8'h40, 32'h0F);
        rd_chk("R10 steer kept", 8'h0C, 32'hE);
        rd_chk("R10 pmu kept", 8'h10, 32'h3);

        // R11: write timing and same-cycle level path
        drive(16'h1000, 0, 0, 0);
        check("R11 core3 off", {31'b0, core_irq[3]}, 0);
        @(negedge clk);
        bus_we = 1; bus_addr = 8'h4C; bus_wdata = 32'h1;
        #1 check("R11 before edge", {31'b0, core_irq[3]}, 0);
        @(negedge clk);
        bus_we = 0;
        #1 check("R11 after edge", {31'b0, core_irq[3]}, 1);
        timer_lvl = 0;
        #1 check("R11 level drop same cycle", {31'b0, core_irq[3]}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule